// File: doc/BRIEF.md
# Clock Synthesizer Test Pin and Output Divider

This block forms the two outputs of a clock synthesizer: the main clock output and a single test pin. A post-divider on the main output divides its source by 1, 2, 4 or 8. A modulus counter emits one pulse for every M source edges. An eight-way selector, steered by a 3-bit test code, puts one of eight things on the test pin: a constant level, the tail bit of the serial configuration register, the reference clock, the modulus counter output, the main output, or the main output divided by four.

One test code is a bypass. In bypass the serial clock takes the place of the oscillator clock as the source of both dividers. The post-divider then drives the main output from the serial clock, and the modulus counter pulses appear on the test pin. This lets a board exercise its clock tree at low speed without the oscillator. All three incoming clocks are treated as sampled signals. They pass through synchronizers into one fast sampling clock, so every divider is a plain synchronous counter that advances on detected rising edges. Any change to the latched settings restarts both dividers.

Top module: `tclk_outsel`

## Requirements
- R1: With test code 000 the test pin follows the serial-register tail bit, with one sampling cycle of delay.
- R2: Test code 001 holds the test pin at 1 and test code 101 holds it at 0, starting from the sampling cycle after the code is applied.
- R3: Test code 010 puts the synchronized reference clock on the test pin, so every reference rising edge gives exactly one test-pin rising edge.
- R4: The modulus counter gives one pulse per M rising edges of its source clock, where M is the 9-bit modulus field. An M of 0 behaves like 1. Test code 011 shows these pulses on the test pin.
- R5: Test code 100 copies the main output onto the test pin, and test code 111 puts the main output divided by four on it. Its first rising edge comes on the second rising edge of the main output after a restart.
- R6: The 2-bit ratio field sets the post-divider to 00 = divide by 2, 01 = divide by 4, 10 = divide by 8, 11 = divide by 1. Divide by 1 passes the source clock level straight through. For the even ratios R, the first rising edge of the output comes R/2 source rising edges after a restart.
- R7: Test code 110 (bypass) clocks both dividers from the serial clock. The main output is the post-divided serial clock, the test pin carries the modulus pulses, and edges on the oscillator clock have no effect.
- R8: With any test code other than 110 the dividers are clocked by the oscillator clock, and serial-clock edges have no effect on the main output.
- R9: Each modulus pulse is exactly one sampling cycle wide.
- R10: Any change of the test code, modulus or ratio field clears both dividers: the main output goes to 0 and the counting restarts from the start of a period.
- R11: While reset is asserted, both the main output and the test pin are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| vco_clk | input | 1 | Oscillator clock, sampled |
| ref_clk | input | 1 | Reference clock, sampled |
| ser_clk | input | 1 | Serial configuration clock, sampled |
| shift_tail | input | 1 | Last bit of the serial configuration register |
| t_code | input | 3 | Test pin selection code |
| m_val | input | 9 | Modulus counter value |
| n_sel | input | 2 | Post-divider ratio code |
| fout | output | 1 | Main clock output |
| test_out | output | 1 | Test pin |

## Verification
The latency of each result is fixed. A constant level or the tail bit reaches the test pin one cycle after the code or bit is applied. A source edge reaches the main output three cycles later: two synchronizer stages and the divider register. It reaches the test pin one cycle after that. The bench holds every source quiet while it changes a setting, so the restart in R10 is complete before a count window opens. It then drives a whole number of source periods and keeps the window open twelve idle cycles past the last edge. Only then does the monitor compare the edge counts and levels it has gathered against the values the driver queued, so each compare falls well after the latest due cycle.

// File: rtl/tclk_pkg.sv
package tclk_pkg;

  typedef enum logic [2:0] {
    TC_SHIFT  = 3'b000,
    TC_HIGH   = 3'b001,
    TC_REF    = 3'b010,
    TC_MCNT   = 3'b011,
    TC_FOUT   = 3'b100,
    TC_LOW    = 3'b101,
    TC_BYPASS = 3'b110,
    TC_FDIV4  = 3'b111
  } tcode_e;

  localparam int SRC_VCO = 0;
  localparam int SRC_REF = 1;
  localparam int SRC_SER = 2;
  localparam int SRC_CNT = 3;

  // Division ratio for the 2-bit post-divider code.
  function automatic logic [3:0] n_ratio(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd2;
      2'b01:   return 4'd4;
      2'b10:   return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

  // Last count value of a half period for an even ratio.
  function automatic logic [2:0] half_last(input logic [3:0] ratio);
    logic [3:0] h;
    h = (ratio >> 1) - 4'd1;
    return h[2:0];
  endfunction

endpackage

// File: rtl/tclk_edge_sampler.sv
module tclk_edge_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lvl,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign lvl  = chain[LAST];
  assign rise = chain[LAST] & ~chain[STAGES];

  // Two detected edges can never fall in adjacent cycles.
  assert_rise_spaced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/tclk_ndiv.sv
module tclk_ndiv
  import tclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       src_lvl,
  input  logic       src_rise,
  input  logic [1:0] n_sel,
  output logic       div_q
);
  logic [3:0] ratio;
  logic [2:0] last;
  logic [2:0] cnt;
  logic       pass_thru;
  logic       half_done;

  assign ratio     = n_ratio(n_sel);
  assign last      = half_last(ratio);
  assign pass_thru = (ratio == 4'd1);
  assign half_done = (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else if (pass_thru) begin
      cnt   <= '0;
      div_q <= src_lvl;
    end else if (src_rise) begin
      if (half_done) begin
        cnt   <= '0;
        div_q <= ~div_q;
      end else begin
        cnt   <= cnt + 3'd1;
      end
    end
  end

  assert_clear_drops_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !div_q);

  assert_moves_only_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_thru && !src_rise && !clr) |=> $stable(div_q));

endmodule

// File: rtl/tclk_mcount.sv
module tclk_mcount #(
  parameter int MW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          src_rise,
  input  logic [MW-1:0] m_val,
  output logic          pulse
);
  localparam logic [MW-1:0] ONE = MW'(1);

  logic [MW-1:0] cnt;
  logic          term;
  logic [MW-1:0] ceil_m;

  assign term   = (cnt <= ONE);
  assign ceil_m = (m_val == '0) ? ONE : m_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (clr) begin
      cnt   <= m_val;
      pulse <= 1'b0;
    end else if (src_rise) begin
      pulse <= term;
      cnt   <= term ? m_val : cnt - ONE;
    end else begin
      pulse <= 1'b0;
    end
  end

  assert_pulse_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (cnt <= ceil_m));

  assert_pulse_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(src_rise));

endmodule

// File: rtl/tclk_outsel.sv
module tclk_outsel
  import tclk_pkg::*;
#(
  parameter int MW          = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vco_clk,
  input  logic          ref_clk,
  input  logic          ser_clk,
  input  logic          shift_tail,
  input  logic [2:0]    t_code,
  input  logic [MW-1:0] m_val,
  input  logic [1:0]    n_sel,
  output logic          fout,
  output logic          test_out
);
  localparam int CFG_W = 3 + MW + 2;

  logic [SRC_CNT-1:0] raw_clk;
  logic [SRC_CNT-1:0] s_lvl;
  logic [SRC_CNT-1:0] s_rise;

  assign raw_clk[SRC_VCO] = vco_clk;
  assign raw_clk[SRC_REF] = ref_clk;
  assign raw_clk[SRC_SER] = ser_clk;

  for (genvar i = 0; i < SRC_CNT; i++) begin : g_samp
    tclk_edge_sampler #(.STAGES(SYNC_STAGES)) samp_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (raw_clk[i]),
      .lvl      (s_lvl[i]),
      .rise     (s_rise[i])
    );
  end

  // Settings change detection: restarts both dividers.
  logic [CFG_W-1:0] cfg_now;
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_chg;

  assign cfg_now = {t_code, m_val, n_sel};
  assign cfg_chg = (cfg_now != cfg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_now;
  end

  // Source selection for the dividers.
  logic bypass;
  logic src_lvl;
  logic src_rise;

  assign bypass   = (tcode_e'(t_code) == TC_BYPASS);
  assign src_lvl  = bypass ? s_lvl[SRC_SER]  : s_lvl[SRC_VCO];
  assign src_rise = bypass ? s_rise[SRC_SER] : s_rise[SRC_VCO];

  tclk_ndiv post_div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cfg_chg),
    .src_lvl  (src_lvl),
    .src_rise (src_rise),
    .n_sel    (n_sel),
    .div_q    (fout)
  );

  // Divide-by-four of the main output, reusing the post-divider.
  logic fout_prev;
  logic fout_rise;
  logic fout_q4;

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_chg) fout_prev <= 1'b0;
    else                   fout_prev <= fout;
  end

  assign fout_rise = fout & ~fout_prev;

  tclk_ndiv quarter_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cfg_chg),
    .src_lvl  (fout),
    .src_rise (fout_rise),
    .n_sel    (2'b01),
    .div_q    (fout_q4)
  );

  logic m_pulse;

  tclk_mcount #(.MW(MW)) mcnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cfg_chg),
    .src_rise (src_rise),
    .m_val    (m_val),
    .pulse    (m_pulse)
  );

  // Test pin selector, registered.
  logic test_nxt;

  always_comb begin
    case (tcode_e'(t_code))
      TC_SHIFT:  test_nxt = shift_tail;
      TC_HIGH:   test_nxt = 1'b1;
      TC_REF:    test_nxt = s_lvl[SRC_REF];
      TC_MCNT:   test_nxt = m_pulse;
      TC_FOUT:   test_nxt = fout;
      TC_LOW:    test_nxt = 1'b0;
      TC_BYPASS: test_nxt = m_pulse;
      default:   test_nxt = fout_q4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) test_out <= 1'b0;
    else        test_out <= test_nxt;
  end

  assert_code_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code == 3'b001) |=> test_out);

  assert_code_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code == 3'b101) |=> !test_out);

  assert_tail_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code == 3'b000) |=> (test_out == $past(shift_tail)));

  assert_bypass_ignores_vco_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !s_rise[SRC_SER] && !cfg_chg && n_sel != 2'b11) |=> $stable(fout));

endmodule

// File: tb/tclk_outsel_tb_top.sv
module tclk_outsel_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vco_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       ser_clk = 1'b0;
  logic       shift_tail = 1'b0;
  logic [2:0] t_code = 3'b000;
  logic [8:0] m_val = 9'd0;
  logic [1:0] n_sel = 2'b00;
  logic       fout;
  logic       test_out;

  always #10 clk = ~clk;

  tclk_outsel dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .vco_clk    (vco_clk),
    .ref_clk    (ref_clk),
    .ser_clk    (ser_clk),
    .shift_tail (shift_tail),
    .t_code     (t_code),
    .m_val      (m_val),
    .n_sel      (n_sel),
    .fout       (fout),
    .test_out   (test_out)
  );

  // Kinds of observation the monitor compares.
  localparam int K_FRISE = 0;
  localparam int K_TRISE = 1;
  localparam int K_TLVL  = 2;
  localparam int K_FLVL  = 3;
  localparam int K_TRUN  = 4;

  string tag_q[$];
  int    kind_q[$];
  int    val_q[$];

  int  total = 0;
  int  bad = 0;
  bit  win_clear = 1'b0;
  bit  win_close = 1'b0;
  bit  finished = 1'b0;

  int  f_rises = 0, t_rises = 0, run_len = 0, max_run = 0;
  bit  f_prev = 1'b0, t_prev = 1'b0;

  // Monitor: gathers edge counts and compares queued expectations.
  always @(negedge clk) begin
    if (win_clear) begin
      f_rises = 0; t_rises = 0; run_len = 0; max_run = 0;
    end else begin
      if (fout && !f_prev) f_rises++;
      if (test_out && !t_prev) t_rises++;
      if (test_out) begin
        run_len++;
        if (run_len > max_run) max_run = run_len;
      end else begin
        run_len = 0;
      end
    end
    f_prev = fout;
    t_prev = test_out;
    if (win_close) begin
      while (kind_q.size() > 0) begin
        string tg;
        int    kd;
        int    ev;
        int    act;
        tg = tag_q.pop_front();
        kd = kind_q.pop_front();
        ev = val_q.pop_front();
        case (kd)
          K_FRISE: act = f_rises;
          K_TRISE: act = t_rises;
          K_TLVL:  act = int'(test_out);
          K_FLVL:  act = int'(fout);
          default: act = max_run;
        endcase
        total++;
        if (act != ev) begin
          bad++;
          $display("FAIL %s kind=%0d actual=%0d expected=%0d", tg, kd, act, ev);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_item(input string tg, input int kd, input int v);
    tag_q.push_back(tg);
    kind_q.push_back(kd);
    val_q.push_back(v);
  endtask

  task automatic set_cfg(input logic [2:0] t, input logic [8:0] m, input logic [1:0] n);
    t_code = t; m_val = m; n_sel = n;
    step(4);
  endtask

  task automatic open_window();
    win_clear = 1'b1;
    step(1);
    win_clear = 1'b0;
  endtask

  task automatic close_window();
    step(12);
    win_close = 1'b1;
    step(1);
    win_close = 1'b0;
  endtask

  task automatic pulse_src(input int which, input int k);
    for (int i = 0; i < k; i++) begin
      if (which == 0) vco_clk = 1'b1; else if (which == 1) ref_clk = 1'b1; else ser_clk = 1'b1;
      step(4);
      vco_clk = 1'b0; ref_clk = 1'b0; ser_clk = 1'b0;
      step(4);
    end
  endtask

  // Driver: one count window with its expected results.
  task automatic run_counts(input string tg, input int which, input int k,
                            input int exp_f, input int exp_t);
    open_window();
    expect_item(tg, K_FRISE, exp_f);
    expect_item(tg, K_TRISE, exp_t);
    pulse_src(which, k);
    close_window();
  endtask

  initial begin
    step(2);
    // R11: outputs low during reset
    expect_item("R11 test", K_TLVL, 0);
    expect_item("R11 fout", K_FLVL, 0);
    close_window();
    rst_n = 1'b1;
    step(3);

    // R1: tail bit on the test pin
    set_cfg(3'b000, 9'd0, 2'b00);
    shift_tail = 1'b1;
    expect_item("R1 tail=1", K_TLVL, 1);
    close_window();
    shift_tail = 1'b0;
    expect_item("R1 tail=0", K_TLVL, 0);
    close_window();

    // R2: fixed levels
    set_cfg(3'b001, 9'd0, 2'b00);
    expect_item("R2 high", K_TLVL, 1);
    close_window();
    set_cfg(3'b101, 9'd0, 2'b00);
    expect_item("R2 low", K_TLVL, 0);
    close_window();

    // R3: reference clock
    set_cfg(3'b010, 9'd0, 2'b00);
    open_window();
    expect_item("R3 ref edges", K_TRISE, 10);
    pulse_src(1, 10);
    close_window();

    // R4, R6: modulus 3 and divide by 2 from the oscillator
    set_cfg(3'b011, 9'd3, 2'b00);
    run_counts("R4 R6 m3 div2", 0, 24, 12, 8);
    // R9: pulses are one cycle wide
    set_cfg(3'b011, 9'd1, 2'b00);
    open_window();
    expect_item("R9 width", K_TRUN, 1);
    expect_item("R9 count", K_TRISE, 8);
    pulse_src(0, 8);
    close_window();
    // R4: modulus 0 acts as 1
    set_cfg(3'b011, 9'd0, 2'b00);
    run_counts("R4 m0", 0, 6, 3, 6);

    // R5: main output and its quarter on the test pin
    set_cfg(3'b100, 9'd3, 2'b01);
    run_counts("R5 R6 fout div4", 0, 16, 4, 4);
    set_cfg(3'b111, 9'd3, 2'b00);
    run_counts("R5 quarter", 0, 24, 12, 3);

    // R6: divide by 8 and by 1
    set_cfg(3'b100, 9'd3, 2'b10);
    run_counts("R6 div8", 0, 32, 4, 4);
    set_cfg(3'b100, 9'd3, 2'b11);
    run_counts("R6 div1", 0, 16, 16, 16);

    // R8: serial clock ignored outside bypass
    set_cfg(3'b100, 9'd3, 2'b00);
    run_counts("R8 ser ignored", 2, 16, 0, 0);

    // R7: bypass from the serial clock
    set_cfg(3'b110, 9'd5, 2'b10);
    run_counts("R7 bypass m5 div8", 2, 40, 5, 8);
    run_counts("R7 vco ignored", 0, 16, 0, 0);
    set_cfg(3'b110, 9'd0, 2'b11);
    run_counts("R7 bypass m0 div1", 2, 16, 16, 16);

    // R10: settings change restarts the post-divider
    set_cfg(3'b100, 9'd3, 2'b10);
    pulse_src(0, 3);
    set_cfg(3'b100, 9'd4, 2'b10);
    open_window();
    expect_item("R10 restart rises", K_FRISE, 0);
    expect_item("R10 restart level", K_FLVL, 0);
    pulse_src(0, 2);
    close_window();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule